// File: doc/BRIEF.md
# Sensor Sample FIFO with Selectable Modes

This block buffers three-axis angular-rate samples between a sampling engine and a reader. Each output-data-rate period the sampling engine presents one 48-bit sample (three 16-bit axis words) with a single-cycle valid pulse. The reader takes samples from the head of the buffer with a pop strobe. The buffer holds 32 samples. A two-bit mode field selects its behaviour: disabled (the buffer is flushed and held empty), circular (when full, the oldest sample gives way to the newest) or stop (when full, newer samples are refused).

A status byte reports the occupancy, a watermark flag and an overflow flag. An event byte reports whether either flag is up. It also reports how many sample periods have gone by since the flags first rose, so software can tell how stale a buffered burst is. The interrupt routing and register access are handled outside this block.

Top module: `sfifo_sensor`

## Requirements
- R1: Status bits 5:0 hold the number of stored samples (0 to 32). `head_o` shows the oldest stored sample whenever that count is nonzero, and samples leave in arrival order.
- R2: Status bit 6 is 1 exactly when the buffer is enabled and the count is greater than or equal to the 6-bit watermark input.
- R3: Status bit 7 is set by a sample that arrives while the count is 32 and no pop is accepted in the same cycle. It stays set until pops bring the count below 32.
- R4: In mode 01 (circular), a sample that arrives when the buffer is full without a pop drops the oldest sample and stores the new one. The count stays at 32.
- R5: In mode 10 (stop), a sample that arrives when the buffer is full without a pop is discarded. The stored contents and the head are unchanged.
- R6: While mode is 00, or the reserved value 11, the buffer is emptied, all flags read 0, and both samples and pops are ignored.
- R7: Event byte bit 5 is the OR of the watermark and overflow flags. Bits 4:0 hold the event time. Bits 7:6 read 0.
- R8: While the event flag is 1 at a clock edge, each valid sample increments the event time, which saturates at 31. At the edge after the event flag reads 0, the event time returns to 0.
- R9: A pop with an empty buffer has no effect. A pop and a sample in the same cycle leave the count unchanged when the buffer is not empty.
- R10: After reset the count, the overflow flag and the event time are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | One-cycle pulse per sample period |
| smp_data_i | input | 48 | Sample: Z in 47:32, Y in 31:16, X in 15:0 |
| pop_i | input | 1 | Remove the head sample |
| mode_i | input | 2 | 00 off, 01 circular, 10 stop, 11 treated as off |
| wmark_i | input | 6 | Watermark count |
| head_o | output | 48 | Oldest stored sample, 0 when empty |
| stat_o | output | 8 | {overflow, watermark, count[5:0]} |
| evt_o | output | 8 | {2'b00, event, event time[4:0]} |

## Verification
The hardest states to reach are a saturated event time and an overflow that stays set while the circular buffer keeps replacing its oldest entry. Both need more than 32 consecutive valid samples with no pops. A low watermark must also hold the event flag up the whole time. The stimulus sweeps both active modes against watermarks from 0 to above 32. Each sweep overfills the buffer by eight samples, runs simultaneous push and pop at the full boundary, and then drains past empty. After that, a long pseudo-random phase mixes modes, including the disabled and reserved values, and changes the watermark while the buffer is partly full.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic [1:0] {
    FM_OFF  = 2'b00,
    FM_CIRC = 2'b01,
    FM_STOP = 2'b10,
    FM_RSVD = 2'b11
  } fmode_e;
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DEPTH = 32,
  parameter int SMP_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic             rd_adv,
  input  logic [SMP_W-1:0] wr_data,
  output logic [SMP_W-1:0] rd_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [SMP_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
    end else begin
      if (wr_en)  wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rd_adv) rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) mem[wr_ptr_q] <= wr_data;
  end

  assign rd_data = mem[rd_ptr_q];
endmodule

// File: rtl/sfifo_occ.sv
module sfifo_occ
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmode_e           mode,
  input  logic             smp_valid,
  input  logic             pop,
  input  logic [5:0]       wmark,
  output logic             flush,
  output logic             wr_en,
  output logic             rd_adv,
  output logic [CNT_W-1:0] cnt,
  output logic             wm_flag,
  output logic             ovf_flag
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             off, circ, full, do_pop, ovf_evt, drop_old;

  always_comb begin
    off      = (mode == FM_OFF) || (mode == FM_RSVD);
    circ     = (mode == FM_CIRC);
    full     = (cnt_q == FULL_CNT);
    do_pop   = pop && (cnt_q != '0) && !off;
    ovf_evt  = smp_valid && !off && full && !do_pop;
    drop_old = ovf_evt && circ;
    wr_en    = smp_valid && !off && (!full || do_pop || circ);
    rd_adv   = do_pop || drop_old;
    flush    = off;

    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (off) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      cnt_d = cnt_q + CNT_W'(wr_en) - CNT_W'(rd_adv);
      ovf_d = (ovf_q || ovf_evt) && (cnt_d == FULL_CNT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt      = cnt_q;
  assign ovf_flag = ovf_q;
  assign wm_flag  = !off && ((CNT_W + 1)'(cnt_q) >= (CNT_W + 1)'(wmark));

  AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT); // R1
  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == FULL_CNT)); // R3
  AST_CIRC_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_CIRC && full && smp_valid && !pop) |=> (cnt_q == FULL_CNT && ovf_q)); // R4
  AST_OFF_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (cnt_q == '0 && !ovf_q)); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && pop && !smp_valid) |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/sfifo_evtimer.sv
module sfifo_evtimer #(
  parameter int TIME_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              tick,
  output logic [TIME_W-1:0] etime
);
  localparam logic [TIME_W-1:0] TOP = '1;

  logic [TIME_W-1:0] etime_q, etime_d;
  logic              cnt_en;

  always_comb begin
    cnt_en  = evt && tick && (etime_q != TOP);
    etime_d = etime_q;
    if (!evt)        etime_d = '0;
    else if (cnt_en) etime_d = etime_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) etime_q <= '0;
    else        etime_q <= etime_d;
  end

  assign etime = etime_q;

  AST_ETIME_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && etime_q == TOP) |=> (etime_q == TOP)); // R8
  AST_ETIME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> (etime_q == '0)); // R8
  AST_ETIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !tick) |=> $stable(etime_q)); // R8
endmodule

// File: rtl/sfifo_sensor.sv
module sfifo_sensor
  import sfifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int AXIS_W = 16,
  parameter int AXES   = 3,
  parameter int TIME_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_valid_i,
  input  logic [AXIS_W*AXES-1:0] smp_data_i,
  input  logic                   pop_i,
  input  logic [1:0]             mode_i,
  input  logic [5:0]             wmark_i,
  output logic [AXIS_W*AXES-1:0] head_o,
  output logic [7:0]             stat_o,
  output logic [7:0]             evt_o
);
  localparam int SMP_W = AXIS_W * AXES;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  fmode_e           mode;
  logic             flush, wr_en, rd_adv, wm_flag, ovf_flag, evt;
  logic [CNT_W-1:0] cnt;
  logic [SMP_W-1:0] rd_data;
  logic [TIME_W-1:0] etime;

  assign mode = fmode_e'(mode_i);

  sfifo_store #(.DEPTH(DEPTH), .SMP_W(SMP_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
    .rd_adv(rd_adv), .wr_data(smp_data_i), .rd_data(rd_data)
  );

  sfifo_occ #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .mode(mode), .smp_valid(smp_valid_i),
    .pop(pop_i), .wmark(wmark_i), .flush(flush), .wr_en(wr_en),
    .rd_adv(rd_adv), .cnt(cnt), .wm_flag(wm_flag), .ovf_flag(ovf_flag)
  );

  assign evt = wm_flag || ovf_flag;

  sfifo_evtimer #(.TIME_W(TIME_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .evt(evt), .tick(smp_valid_i), .etime(etime)
  );

  assign head_o = (cnt != '0) ? rd_data : '0;
  assign stat_o = {ovf_flag, wm_flag, 6'(cnt)};
  assign evt_o  = {2'b00, evt, 5'(etime)};

  AST_STOP_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_STOP && cnt == CNT_W'(DEPTH) && smp_valid_i && !pop_i) |=> $stable(head_o)); // R5
  AST_EVT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o[7:6] == 2'b00); // R7
endmodule

// File: tb/test_sfifo_sensor.sv
`timescale 1ns/1ps
module test_sfifo_sensor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid_i, pop_i;
  logic [47:0] smp_data_i;
  logic [1:0]  mode_i;
  logic [5:0]  wmark_i;
  logic [47:0] head_o;
  logic [7:0]  stat_o, evt_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [47:0] q[$];
  bit          m_ovf;
  int          m_etime;
  int unsigned lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  sfifo_sensor i_sfifo_sensor (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .pop_i(pop_i), .mode_i(mode_i), .wmark_i(wmark_i),
    .head_o(head_o), .stat_o(stat_o), .evt_o(evt_o)
  );

  function automatic int unsigned next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic chk(input bit ok, input string req, input string phase,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s) actual=%0h expected=%0h at %0t", req, phase, act, exp, $time);
    end
  endtask

  task automatic compare(input string phase);
    bit off;
    bit wm;
    off = (mode_i == 2'b00) || (mode_i == 2'b11);
    wm  = !off && (q.size() >= int'(wmark_i));
    chk(stat_o[5:0] == 6'(q.size()), "R1", phase, stat_o[5:0], q.size());
    chk(stat_o[6] == wm, "R2", phase, stat_o[6], wm);
    chk(stat_o[7] == m_ovf, "R3", phase, stat_o[7], m_ovf);
    chk(evt_o[5] == (wm | m_ovf) && evt_o[7:6] == 2'b00, "R7", phase, evt_o[7:5], {2'b00, wm | m_ovf});
    chk(evt_o[4:0] == 5'(m_etime), "R8", phase, evt_o[4:0], m_etime);
    if (q.size() != 0)
      chk(head_o == q[0], "R1", phase, head_o, q[0]);
  endtask

  // one clock: inputs set at the falling edge, results checked at the next one
  task automatic step(input bit v, input bit p, input logic [47:0] d, input string phase);
    bit off, circ, pre_evt, did_pop, full_before, ovf_evt;
    off  = (mode_i == 2'b00) || (mode_i == 2'b11);
    circ = (mode_i == 2'b01);
    pre_evt = (!off && (q.size() >= int'(wmark_i))) || m_ovf;
    smp_valid_i = v;
    pop_i       = p;
    smp_data_i  = d;
    @(posedge clk);
    ovf_evt = 0;
    if (off) begin
      q.delete();
      m_ovf = 0;
    end else begin
      full_before = (q.size() == 32);
      did_pop = p && (q.size() > 0);
      if (did_pop) void'(q.pop_front());
      if (v) begin
        if (full_before && !did_pop) begin
          ovf_evt = 1;
          if (circ) begin
            void'(q.pop_front());
            q.push_back(d);
          end
        end else begin
          q.push_back(d);
        end
      end
      m_ovf = (m_ovf || ovf_evt) && (q.size() == 32);
    end
    if (!pre_evt) m_etime = 0;
    else if (v && m_etime < 31) m_etime++;
    @(negedge clk);
    smp_valid_i = 0;
    pop_i       = 0;
    compare(phase);
  endtask

  function automatic logic [47:0] rand_smp();
    logic [47:0] s;
    s[31:0]  = next_rand();
    s[47:32] = 16'(next_rand());
    return s;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int wm_list[7] = '{0, 1, 7, 16, 31, 32, 45};
    string ph;
    rst_n = 0;
    smp_valid_i = 0;
    pop_i = 0;
    smp_data_i = '0;
    mode_i = 2'b01;
    wmark_i = 6'd40;
    m_ovf = 0;
    m_etime = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk(stat_o == 8'h00, "R10", "reset", stat_o, 8'h00);
    chk(evt_o == 8'h00, "R10", "reset", evt_o, 8'h00);

    // directed sweeps over both active modes and several watermarks
    for (int m = 1; m <= 2; m++) begin
      foreach (wm_list[k]) begin
        ph = (m == 1) ? "R4" : "R5";
        mode_i = 2'b00;
        step(1, 0, rand_smp(), "R6");
        mode_i = 2'(m);
        wmark_i = 6'(wm_list[k]);
        for (int i = 0; i < 40; i++) step(1, 0, {8'(m), 8'(k), 32'(i * 32'h0101_0007)}, ph);
        for (int i = 0; i < 5; i++) step(1, 1, rand_smp(), "R9");
        step(0, 1, '0, "R3");
        step(1, 0, rand_smp(), ph);
        for (int i = 0; i < 36; i++) step(0, 1, '0, "R9");
        step(1, 1, rand_smp(), "R9");
      end
    end

    // off and reserved modes ignore samples and pops
    mode_i = 2'b01;
    wmark_i = 6'd3;
    for (int i = 0; i < 10; i++) step(1, 0, rand_smp(), "R4");
    mode_i = 2'b00;
    for (int i = 0; i < 4; i++) step(1, 1, rand_smp(), "R6");
    mode_i = 2'b11;
    for (int i = 0; i < 4; i++) step(1, 0, rand_smp(), "R6");

    // pseudo-random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = next_rand();
      if (r[7:0] < 8'd6) mode_i = 2'(r[9:8]);
      else if (r[7:0] < 8'd12) mode_i = 2'(1 + r[8]);
      if (r[15:10] == 6'd0) wmark_i = 6'(r[21:16]);
      step(r[24] | r[25], r[26] & r[27] & r[28], rand_smp(), "R9");
    end

    finish_run();
  end
endmodule